// File: doc/BRIEF.md
# Strided Interleaved Banked Vector Loader

This block fetches a vector from memory one element at a time. Software supplies a starting byte address, a signed byte stride and an element count. The block then works out the address of each element and sends it to one of several memory banks. The banks are interleaved on the low-order bits of the 8-byte word address. Each bank latches the address it is given and stays occupied for a fixed access time. When that time is up it hands back the word. The loader issues at most one address per clock. When the bank an element needs is still occupied, that element waits, and every later element waits behind it. Element order is never broken.

Returned words appear on a write port in element order, each with its element index, ready to be written into a vector register. A done flag rises after the last element has come back and stays high until the next start. The bank contents come from an internal array model that is filled with a fixed pattern at reset. With unit stride and at least as many banks as cycles of access time, one element streams out every clock.

Top module: `vec_loader`

## Requirements
- R1: Element k is read from byte address (base + k*stride) modulo 2^AW, where AW is 12 by default. Its data equals 0xD0000000 OR g, zero-extended to DW bits, with g = (that address >> 3) modulo 512.
- R2: The bank for an address is (address >> 3) mod NUM_BANKS. A bank accepts no new element until ACCESS cycles have passed since it latched its previous one.
- R3: An element issued at a clock edge appears on wr_valid/wr_idx/wr_data exactly ACCESS edges later. The first element of an unblocked run is issued at the first edge after the edge that captures start.
- R4: At most one element is issued per edge, in increasing index order. An element blocked by a busy bank stalls all later elements until that bank is free.
- R5: With an 8-byte stride and 8 banks, 6-cycle access, 64 elements from byte address 136, one element returns on every cycle for 64 consecutive cycles.
- R6: wr_idx runs 0, 1, ..., len-1 across the wr_valid cycles of a run.
- R7: done rises one cycle after the final wr_valid and holds until the next accepted start. With len 0, done rises one cycle after start. wr_valid is never high while done is high.
- R8: A start pulse that arrives while a run is in progress has no effect on that run's addresses, indices, data or timing.
- R9: After reset, wr_valid and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a vector load when idle |
| base | input | AW | Starting byte address |
| stride | input | AW | Signed byte stride between elements |
| len | input | LW | Element count, 0 to MAXLEN |
| wr_valid | output | 1 | A returned element is present |
| wr_idx | output | LW | Element index of the returned word |
| wr_data | output | DW | Returned word |
| done | output | 1 | Run finished, held until next start |

## Verification
In the same clock, a bank can hand back one element while it latches the address of another. With a stride that sends every element to one bank, the return of element k and the issue of element k+1 land on the same edge. Each task compares the wr_valid cycle, the index and the data of every element against a bench model of issue times built from the bank-busy rule, so a collision that loses or corrupts either event shows up as a wrong cycle or wrong data. A second start driven in the middle of a run lines up a start request with ongoing issue and return, and the run must come out unchanged.

// File: rtl/vec_loader.sv
module vec_loader #(
  parameter int NUM_BANKS = 8,
  parameter int ACCESS    = 6,
  parameter int DW        = 64,
  parameter int AW        = 12,
  parameter int MAXLEN    = 64,
  localparam int LW       = $clog2(MAXLEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] stride,
  input  logic [LW-1:0] len,
  output logic          wr_valid,
  output logic [LW-1:0] wr_idx,
  output logic [DW-1:0] wr_data,
  output logic          done
);
  localparam int BB    = $clog2(NUM_BANKS);
  localparam int DEPTH = (2 ** (AW - 3)) / NUM_BANKS;
  localparam int RB    = $clog2(DEPTH);
  localparam int CW    = $clog2(ACCESS + 1);

  logic          active;
  logic [LW-1:0] len_r, iss_n, ret_n;
  logic [AW-1:0] addr, stride_r;

  logic [CW-1:0] cnt   [NUM_BANKS];
  logic [RB-1:0] row_q [NUM_BANKS];
  logic [LW-1:0] idx_q [NUM_BANKS];
  logic [DW-1:0] mem   [NUM_BANKS][DEPTH];

  logic [NUM_BANKS-1:0] issue_vec, ret_vec;
  logic [LW-1:0] sel_idx;
  logic [DW-1:0] sel_data;

  wire [BB-1:0] tgt      = addr[3 +: BB];
  wire [RB-1:0] row      = addr[3 + BB +: RB];
  wire          issue_ok = active && (iss_n != len_r) && (cnt[tgt] <= CW'(1));
  wire          ret_any  = |ret_vec;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign issue_vec[b] = issue_ok && (tgt == BB'(b));
    assign ret_vec[b]   = (cnt[b] == CW'(1));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt[b]   <= '0;
        row_q[b] <= '0;
        idx_q[b] <= '0;
      end else if (issue_vec[b]) begin
        cnt[b]   <= CW'(ACCESS);
        row_q[b] <= row;
        idx_q[b] <= iss_n;
      end else if (cnt[b] != '0) begin
        cnt[b]   <= cnt[b] - CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      for (int b = 0; b < NUM_BANKS; b++)
        for (int r = 0; r < DEPTH; r++)
          mem[b][r] <= DW'(32'hD000_0000 | 32'(r * NUM_BANKS + b));
  end

  always_comb begin
    sel_idx  = '0;
    sel_data = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (ret_vec[b]) begin
        sel_idx  = sel_idx | idx_q[b];
        sel_data = sel_data | mem[b][row_q[b]];
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= ret_any;
      wr_idx   <= sel_idx;
      wr_data  <= sel_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      done     <= 1'b0;
      len_r    <= '0;
      iss_n    <= '0;
      ret_n    <= '0;
      addr     <= '0;
      stride_r <= '0;
    end else if (!active) begin
      if (start) begin
        active   <= 1'b1;
        done     <= 1'b0;
        len_r    <= len;
        iss_n    <= '0;
        ret_n    <= '0;
        addr     <= base;
        stride_r <= stride;
      end
    end else begin
      if (issue_ok) begin
        iss_n <= iss_n + LW'(1);
        addr  <= addr + stride_r;
      end
      if (ret_any) ret_n <= ret_n + LW'(1);
      if (ret_n == len_r) begin
        active <= 1'b0;
        done   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vec_loader_chk.sv
module vec_loader_chk #(
  parameter int NUM_BANKS = 8,
  parameter int ACCESS    = 6,
  parameter int LW        = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_BANKS-1:0] issue_vec,
  input logic                 wr_valid,
  input logic [LW-1:0]        wr_idx,
  input logic                 done
);
  localparam int SW = $clog2(ACCESS + 1);

  logic [LW-1:0] exp_idx;
  logic [LW:0]   outst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_idx <= '0;
      outst   <= '0;
    end else begin
      if (done) exp_idx <= '0;
      else if (wr_valid) exp_idx <= exp_idx + LW'(1);
      outst <= outst + (LW+1)'(|issue_vec) - (LW+1)'(wr_valid);
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_since
    logic [SW-1:0] since;
    always_ff @(posedge clk) begin
      if (!rst_n) since <= SW'(ACCESS);
      else if (issue_vec[b]) since <= SW'(1);
      else if (since < SW'(ACCESS)) since <= since + SW'(1);
    end
    assert_bank_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      issue_vec[b] |-> since >= SW'(ACCESS));
  end

  assert_one_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(issue_vec));

  assert_return_after_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> outst != '0);

  assert_idx_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_idx == exp_idx);

  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_valid);

  assert_reset_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!wr_valid && !done));
endmodule

bind vec_loader vec_loader_chk #(.NUM_BANKS(NUM_BANKS), .ACCESS(ACCESS), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue_vec(issue_vec),
  .wr_valid(wr_valid), .wr_idx(wr_idx), .done(done)
);

// File: tb/tb_vec_loader.sv
`timescale 1ns/1ps
module tb_vec_loader;
  localparam int NB = 8, ACC = 6, DW = 64, AW = 12, LW = 7;

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] base = '0, stride = '0;
  logic [LW-1:0] len = '0;
  logic wr_valid, done;
  logic [LW-1:0] wr_idx;
  logic [DW-1:0] wr_data;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  vec_loader #(.NUM_BANKS(NB), .ACCESS(ACC), .DW(DW), .AW(AW), .MAXLEN(64)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base(base), .stride(stride),
    .len(len), .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_data(wr_data), .done(done));

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int addr_of(int b, int s, int k);
    return (b + k * s) & ((1 << AW) - 1);
  endfunction

  task automatic run_case(string req, int b, int s, int n, int poke_at);
    int iss[64], ret[64], lastb[NB];
    int lastret, donec;
    for (int i = 0; i < NB; i++) lastb[i] = -1000;
    for (int k = 0; k < n; k++) begin
      int bk = (addr_of(b, s, k) >> 3) % NB;
      int t = (k == 0) ? 1 : iss[k-1] + 1;
      if (lastb[bk] + ACC > t) t = lastb[bk] + ACC;
      iss[k] = t; lastb[bk] = t; ret[k] = t + ACC;
    end
    lastret = (n > 0) ? ret[n-1] : 0;
    donec = lastret + 1;
    @(negedge clk);
    base = AW'(b); stride = AW'(s); len = LW'(n); start = 1;
    @(negedge clk);
    start = 0;
    for (int c = 1; c <= donec + 2; c++) begin
      int hit = -1;
      @(negedge clk);
      start = 0;
      for (int k = 0; k < n; k++) if (ret[k] == c) hit = k;
      if (hit >= 0) begin
        longint ed = longint'(32'hD000_0000 | (addr_of(b, s, hit) >> 3));
        chk(wr_valid === 1'b1, req, $sformatf("valid elem %0d cycle %0d", hit, c), wr_valid, 1);
        chk(wr_idx === LW'(hit), req, "index", wr_idx, hit);
        chk(wr_data === DW'(ed), req, $sformatf("data elem %0d", hit), wr_data, ed);
      end else if (wr_valid !== 1'b0) begin
        chk(0, req, $sformatf("spurious valid cycle %0d", c), wr_valid, 0);
      end
      if (c == donec - 1) chk(done === 1'b0, "R7", "done early", done, 0);
      if (c >= donec) chk(done === 1'b1, "R7", $sformatf("done cycle %0d", c), done, 1);
      if (c == poke_at) begin
        base = 12'h700; stride = 12'h010; len = 7'd2; start = 1;
      end
    end
  endtask

  task automatic t_reset();
    chk(wr_valid === 1'b0, "R9", "wr_valid after reset", wr_valid, 0);
    chk(done === 1'b0, "R9", "done after reset", done, 0);
  endtask

  task automatic t_unit();       run_case("R5 R1 R3 R6", 136, 8, 64, -1); endtask
  task automatic t_stride16();   run_case("R4 R2", 136, 16, 12, -1); endtask
  task automatic t_same_bank();  run_case("R2 R3", 64, 64, 6, -1); endtask
  task automatic t_negative();   run_case("R1", 2000, -24, 10, -1); endtask
  task automatic t_wrap();       run_case("R1", 4088, 8, 3, -1); endtask
  task automatic t_len_zero();   run_case("R7", 256, 8, 0, -1); endtask
  task automatic t_busy_start(); run_case("R8", 40, 8, 5, 3); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_unit();
    t_stride16();
    t_same_bank();
    t_negative();
    t_wrap();
    t_len_zero();
    t_busy_start();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule